// File: doc/BRIEF.md
# Prioritized Interruption Vector Generator

This block decides which pending interruption a processor core services next and where the handler code for it is fetched from. Requests arrive as a vector indexed by interruption number, 1 to 29. Each number belongs to one of four classes. Each class is looked at only at its own point of the instruction cycle:

- Class 1, the unrecoverable machine check, is looked at on every clock edge.
- Class 2 is looked at when the instruction-boundary strobe is high.
- Classes 3 and 4 are looked at when execution of the current instruction ends with a fault or trap flagged.

Among the requests that qualify at an edge, the block picks the winner by a fixed ranking, which is not numeric order. It then registers four outputs for one cycle: a take pulse, the winning number, its class, and the handler address. The handler address is the table base plus 32 bytes per interruption number, because each table slot holds eight instruction words. A three-bit enable masks classes 2, 3 and 4. Class 1 cannot be masked. Saving the processor state is left to the surrounding core.

Top module: `intr_vector_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero on that edge.
- R2: When several requests qualify at the same edge, the winner is the earliest number in this ranking, from highest to lowest: 1, 2, 3, 4, 5, 29, 6 through 17 in ascending order, 26, 27, 28, then 18 through 25 in ascending order.
- R3: `grp_o` reports the class of the winning number, coded as the class minus one. Class 1 is code 0 and holds only number 1. Class 2 is code 1 and holds 2 to 5 and 29. Class 3 is code 2 and holds 6 to 22 and 26 to 28. Class 4 is code 3 and holds 23 to 25.
- R4: Request bit 1 wins at every rising edge at which it is high, regardless of the strobes and of `grp_en_i`.
- R5: A class 2 request qualifies only at an edge where `cycle_start_i` is high.
- R6: A class 3 or class 4 request qualifies only at an edge where `exec_done_i` and `exec_excp_i` are both high. When `cycle_start_i` is high at that same edge, class 2 requests qualify as well.
- R7: When `take_o` is high, `vaddr_o` equals the `vbase_i` value sampled at the deciding edge plus 32 times `num_o`.
- R8: `grp_en_i` bit 0 enables class 2, bit 1 enables class 3 and bit 2 enables class 4. A request whose enable bit is low does not qualify.
- R9: After an edge at which no request qualifies, `take_o`, `num_o`, `grp_o` and `vaddr_o` are all zero.
- R10: The outputs are registered. A decision taken at an edge is visible during the following cycle only, so `take_o` is a one-cycle pulse per qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 29 | Pending requests; bit n (1..29) is interruption number n |
| cycle_start_i | input | 1 | Instruction boundary strobe, before the next fetch |
| exec_done_i | input | 1 | End-of-execute strobe |
| exec_excp_i | input | 1 | Fault or trap raised by the executing instruction |
| grp_en_i | input | 3 | Class enables: bit 0 class 2, bit 1 class 3, bit 2 class 4 |
| vbase_i | input | 32 | Vector table base, aligned to 2 KiB |
| take_o | output | 1 | One-cycle pulse: an interruption is taken |
| num_o | output | 5 | Winning interruption number, zero when idle |
| grp_o | output | 2 | Class of the winner, class minus one |
| vaddr_o | output | 32 | Handler fetch address |

## Verification
The state that matters is the one-cycle output register and the ranking logic behind it. If the ranking places a number wrongly, the fault shows only when that number competes with a neighbour in the ranking. For this reason every adjacent pair in the ranking is raised together, and the winner is read in the cycle right after the edge. A wrong class mapping or a wrong sampling point shows in that same cycle, in one of two ways: a take pulse where none may appear, or a wrong value on `grp_o` or `vaddr_o`. A stale output register shows one cycle after its stimulus is removed, as a pulse that lasts longer than one cycle.

// File: rtl/ivg_pkg.sv
// Package: shared constants, class type and the fixed ranking functions
// used by the interruption vector generator. All functions are constant
// functions, usable both in generate conditions and in run-time logic.
package ivg_pkg;

    localparam int MAX_NUM = 29;                 // highest interruption number
    localparam int NUM_W   = $clog2(MAX_NUM + 1); // width of a number
    localparam int RANKS   = MAX_NUM;            // one rank per number

    typedef enum logic [1:0] {
        GRP_1 = 2'd0,
        GRP_2 = 2'd1,
        GRP_3 = 2'd2,
        GRP_4 = 2'd3
    } ivg_grp_e;

    // Class of interruption number n.
    function automatic ivg_grp_e grp_of(input int unsigned n);
        if (n == 1)
            return GRP_1;
        else if ((n >= 2 && n <= 5) || n == 29)
            return GRP_2;
        else if (n >= 23 && n <= 25)
            return GRP_4;
        else
            return GRP_3;
    endfunction

    // Rank of number n; rank 0 is serviced first.
    function automatic int unsigned prio_rank(input int unsigned n);
        if (n <= 5)
            return n - 1;
        else if (n == 29)
            return 5;
        else if (n <= 17)
            return n;
        else if (n >= 26)
            return n - 8;
        else
            return n + 3;
    endfunction

    // Inverse of prio_rank: number holding rank r.
    function automatic logic [NUM_W-1:0] num_at_rank(input int unsigned r);
        int unsigned n;
        if (r <= 4)
            n = r + 1;
        else if (r == 5)
            n = 29;
        else if (r <= 17)
            n = r;
        else if (r <= 20)
            n = r + 8;
        else
            n = r - 3;
        return NUM_W'(n);
    endfunction

endpackage

// File: rtl/ivg_elig_mask.sv
// Module: ivg_elig_mask
// Decides, per interruption number, whether its request qualifies at the
// current edge. Class 1 always qualifies, class 2 needs the boundary
// strobe, classes 3 and 4 need the end-of-execute strobe with the fault
// flag. Classes 2..4 are gated by their enable bit.
// Assumes: strobes are single-cycle and synchronous to clk.
module ivg_elig_mask
    import ivg_pkg::*;
#(
    parameter int N_SRC = MAX_NUM
) (
    input  logic [N_SRC:1] req_i,
    input  logic           cycle_start_i,
    input  logic           exec_hit_i,
    input  logic [2:0]     grp_en_i,
    output logic [N_SRC:1] elig_o
);

    // Qualifying window per class, one term each.
    logic win_g2, win_g3, win_g4;

    // Combine sampling point and enable for each maskable class.
    always_comb begin
        win_g2 = cycle_start_i & grp_en_i[0];
        win_g3 = exec_hit_i    & grp_en_i[1];
        win_g4 = exec_hit_i    & grp_en_i[2];
    end

    // One gate per source, picked by its class at elaboration.
    for (genvar n = 1; n <= N_SRC; n++) begin : g_src
        if (grp_of(n) == GRP_1) begin : g_c1
            assign elig_o[n] = req_i[n];
        end else if (grp_of(n) == GRP_2) begin : g_c2
            assign elig_o[n] = req_i[n] & win_g2;
        end else if (grp_of(n) == GRP_3) begin : g_c3
            assign elig_o[n] = req_i[n] & win_g3;
        end else begin : g_c4
            assign elig_o[n] = req_i[n] & win_g4;
        end
    end

endmodule

// File: rtl/ivg_prio_pick.sv
// Module: ivg_prio_pick
// Reorders the qualifying requests into rank order and picks the first
// set rank, then maps that rank back to its interruption number.
// Assumes: prio_rank is a bijection onto 0..N_SRC-1.
module ivg_prio_pick
    import ivg_pkg::*;
#(
    parameter int N_SRC = MAX_NUM,
    localparam int RW   = $clog2(N_SRC + 1)
) (
    input  logic [N_SRC:1]   elig_i,
    output logic             sel_valid_o,
    output logic [NUM_W-1:0] sel_num_o
);

    logic [N_SRC-1:0] ranked;
    logic [RW-1:0]    best_rank;

    // Wire each number into its rank slot.
    for (genvar n = 1; n <= N_SRC; n++) begin : g_rank
        assign ranked[prio_rank(n)] = elig_i[n];
    end

    // Find the lowest set rank (highest priority).
    always_comb begin
        best_rank = '0;
        for (int r = N_SRC - 1; r >= 0; r--) begin
            if (ranked[r])
                best_rank = RW'(r);
        end
    end

    // Present the winner as a number, zero when nothing qualifies.
    always_comb begin
        sel_valid_o = |ranked;
        sel_num_o   = sel_valid_o ? num_at_rank(int'(best_rank)) : '0;
    end

endmodule

// File: rtl/ivg_vec_addr.sv
// Module: ivg_vec_addr
// Computes the handler fetch address: base plus entry size times number.
// Assumes: ENTRY_BYTES is a power of two; base alignment is the caller's.
module ivg_vec_addr
    import ivg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 32,
    localparam int SHIFT      = $clog2(ENTRY_BYTES)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NUM_W-1:0]  num_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] offset;

    // Scale the number to a byte offset and add the base.
    always_comb begin
        offset = {{(ADDR_W-NUM_W){1'b0}}, num_i} << SHIFT;
        addr_o = base_i + offset;
    end

endmodule

// File: rtl/intr_vector_gen.sv
// Module: intr_vector_gen (top)
// Qualifies pending interruption requests by class and sampling point,
// picks the highest-ranked, and registers a one-cycle take pulse with the
// number, class and handler address.
// Assumes: vbase_i aligned to 2 KiB; synchronous active-low reset.
module intr_vector_gen
    import ivg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_NUM:1]  req_i,
    input  logic              cycle_start_i,
    input  logic              exec_done_i,
    input  logic              exec_excp_i,
    input  logic [2:0]        grp_en_i,
    input  logic [ADDR_W-1:0] vbase_i,
    output logic              take_o,
    output logic [NUM_W-1:0]  num_o,
    output logic [1:0]        grp_o,
    output logic [ADDR_W-1:0] vaddr_o
);

    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [MAX_NUM:1]  elig;
    logic              sel_valid;
    logic [NUM_W-1:0]  sel_num;
    logic [ADDR_W-1:0] sel_addr;
    logic              exec_hit;

    // Execution-side window: instruction finished with a fault or trap.
    always_comb exec_hit = exec_done_i & exec_excp_i;

    ivg_elig_mask #(.N_SRC(MAX_NUM)) u_elig (
        .req_i         (req_i),
        .cycle_start_i (cycle_start_i),
        .exec_hit_i    (exec_hit),
        .grp_en_i      (grp_en_i),
        .elig_o        (elig)
    );

    ivg_prio_pick #(.N_SRC(MAX_NUM)) u_pick (
        .elig_i      (elig),
        .sel_valid_o (sel_valid),
        .sel_num_o   (sel_num)
    );

    ivg_vec_addr #(.ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
        .base_i (vbase_i),
        .num_i  (sel_num),
        .addr_o (sel_addr)
    );

    // Register the decision for exactly one cycle; zeros when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            num_o   <= '0;
            grp_o   <= '0;
            vaddr_o <= '0;
        end else if (sel_valid) begin
            take_o  <= 1'b1;
            num_o   <= sel_num;
            grp_o   <= grp_of(int'(sel_num));
            vaddr_o <= sel_addr;
        end else begin
            take_o  <= 1'b0;
            num_o   <= '0;
            grp_o   <= '0;
            vaddr_o <= '0;
        end
    end

    // Machine check wins on the next cycle regardless of strobes (R4).
    assert_g1_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[1] |=> (take_o && num_o == NUM_W'(1) && grp_o == GRP_1));

    // Class 2 only from a boundary edge with its enable set (R5, R8).
    assert_g2_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && grp_o == GRP_2) |-> ($past(cycle_start_i) && $past(grp_en_i[0])));

    // Class 3/4 only from an execute edge with fault flagged (R6).
    assert_g34_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (grp_o == GRP_3 || grp_o == GRP_4)) |->
            ($past(exec_done_i) && $past(exec_excp_i)));

    // Masked classes never taken (R8).
    assert_mask_respected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && grp_o == GRP_4) |-> $past(grp_en_i[2]));

    // Reported class matches the number (R3).
    assert_class_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (grp_o == grp_of(int'(num_o))));

    // Address is sampled base plus scaled number (R7).
    assert_vaddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vaddr_o == $past(vbase_i) +
                    ({{(ADDR_W-NUM_W){1'b0}}, num_o} << SHIFT)));

    // Idle outputs are all zero (R9).
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (num_o == '0 && grp_o == '0 && vaddr_o == '0));

endmodule

// File: tb/intr_vector_gen_tb.sv
module intr_vector_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [29:1] req;
    logic        cs, ed, ex;
    logic [2:0]  en;
    logic [31:0] base;
    logic        take;
    logic [4:0]  num;
    logic [1:0]  grp;
    logic [31:0] vaddr;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_vector_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cycle_start_i(cs),
        .exec_done_i(ed), .exec_excp_i(ex), .grp_en_i(en), .vbase_i(base),
        .take_o(take), .num_o(num), .grp_o(grp), .vaddr_o(vaddr)
    );

    // Ranking from R2, highest first.
    int order [29] = '{1,2,3,4,5,29,6,7,8,9,10,11,12,13,14,15,16,17,
                       26,27,28,18,19,20,21,22,23,24,25};

    function automatic int exp_grp(input int n);
        if (n == 1) return 0;
        if ((n >= 2 && n <= 5) || n == 29) return 1;
        if (n >= 23 && n <= 25) return 3;
        return 2;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Drive at a falling edge, read at the next falling edge, then idle.
    task automatic apply(input logic [29:1] r, input logic c, input logic d,
                         input logic x, input logic [2:0] e);
        @(negedge clk);
        req = r; cs = c; ed = d; ex = x; en = e;
        @(negedge clk);
        req = '0; cs = 0; ed = 0; ex = 0; en = 3'b111;
    endtask

    task automatic expect_take(input string rq, input int n);
        chk({rq, " take"}, 32'(take), 32'd1);
        chk({rq, " num"}, 32'(num), 32'(n));
        chk({rq, " grp"}, 32'(grp), 32'(exp_grp(n)));
        chk({rq, " vaddr"}, vaddr, base + 32'(n) * 32);
    endtask

    task automatic expect_idle(input string rq);
        chk({rq, " take"}, 32'(take), 32'd0);
        chk({rq, " num"}, 32'(num), 32'd0);
        chk({rq, " grp"}, 32'(grp), 32'd0);
        chk({rq, " vaddr"}, vaddr, 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 0; req = '0; cs = 1; ed = 1; ex = 1; en = 3'b111;
        req[6] = 1;
        repeat (3) @(negedge clk);
        expect_idle("R1 reset");
        req = '0; cs = 0; ed = 0; ex = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_singles();
        for (int n = 1; n <= 29; n++) begin
            logic [29:1] r = '0;
            r[n] = 1'b1;
            if (exp_grp(n) == 1) apply(r, 1, 0, 0, 3'b111);
            else apply(r, 0, 1, 1, 3'b111);
            expect_take("R3 R7 single", n);
        end
    endtask

    task automatic t_pairs();
        for (int i = 0; i < 28; i++) begin
            logic [29:1] r = '0;
            r[order[i]] = 1'b1;
            r[order[i+1]] = 1'b1;
            apply(r, 1, 1, 1, 3'b111);
            chk("R2 pair winner", 32'(num), 32'(order[i]));
        end
        apply('1, 1, 1, 1, 3'b111);
        chk("R2 all pending", 32'(num), 32'd1);
    endtask

    task automatic t_g1_any_time();
        logic [29:1] r = '0;
        r[1] = 1'b1; r[4] = 1'b1; r[7] = 1'b1;
        apply(r, 0, 0, 0, 3'b000);
        expect_take("R4 g1 no strobe masked", 1);
    endtask

    task automatic t_windows();
        logic [29:1] r = '0;
        r[4] = 1'b1;
        apply(r, 0, 1, 1, 3'b111);
        expect_idle("R5 g2 without boundary");
        r = '0; r[12] = 1'b1; r[24] = 1'b1;
        apply(r, 1, 0, 0, 3'b111);
        expect_idle("R6 g3 on boundary only");
        apply(r, 0, 1, 0, 3'b111);
        expect_idle("R6 exec without fault");
        r = '0; r[24] = 1'b1;
        apply(r, 0, 1, 1, 3'b111);
        expect_take("R6 g4 on exec", 24);
        r = '0; r[29] = 1'b1; r[6] = 1'b1;
        apply(r, 1, 1, 1, 3'b111);
        expect_take("R6 union g2 beats g3", 29);
    endtask

    task automatic t_masks();
        logic [29:1] r = '0;
        r[3] = 1'b1;
        apply(r, 1, 0, 0, 3'b110);
        expect_idle("R8 g2 masked");
        r = '0; r[8] = 1'b1; r[23] = 1'b1;
        apply(r, 0, 1, 1, 3'b101);
        expect_take("R8 g3 masked g4 wins", 23);
        apply(r, 0, 1, 1, 3'b011);
        expect_take("R8 g4 masked g3 wins", 8);
        apply(r, 0, 1, 1, 3'b001);
        expect_idle("R8 g3 g4 masked");
    endtask

    task automatic t_pulse();
        logic [29:1] r = '0;
        r[5] = 1'b1;
        apply(r, 1, 0, 0, 3'b111);
        expect_take("R10 pulse high", 5);
        @(negedge clk);
        expect_idle("R10 pulse ends");
        apply('0, 1, 1, 1, 3'b111);
        expect_idle("R9 nothing pending");
    endtask

    initial begin
        base = 32'h8000_1800;
        t_reset();
        t_singles();
        t_pairs();
        t_g1_any_time();
        t_windows();
        base = 32'h0004_0000;
        t_masks();
        t_pulse();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule